// File: doc/BRIEF.md
# Programmable Chip-Select Range Decoder

This block drives one active-low chip-select for a bus that addresses either a 20-bit memory space or a 16-bit I/O space. Two configuration words set the window. A lower block bound is inclusive. An upper block bound is exclusive. Both bounds count 1 KB blocks in memory space and 64-byte blocks in I/O space. An override can stretch the window to the top of the space. A master enable gates the output entirely.

The block also paces the selected bus cycle. It holds its internal ready low for a programmed number of wait states, from 0 to 15. After that it either completes the cycle on its own or waits for an external ready line. Waiting for external ready lets a slow device stretch the cycle beyond fifteen wait states.

A plain one-cycle write port loads the two configuration words. The bus side is described by three signals: an address-valid strobe, a cycle-end pulse and the address.

Top module: `cs_range_decoder`

## Requirements
- R1: After reset, cs_n is 1 and int_rdy is 0. The stored settings are: lower bound 0, wait count 15, ready-ignore 0, upper bound 0, override 0, enable 0.
- R2: A write with cfg_wr_en=1 loads one configuration word at the next clock edge. With cfg_wr_sel=0 it loads the lower word: bits [9:0] are the lower block bound, bits [13:10] the wait count, and bit [14] the ready-ignore flag. With cfg_wr_sel=1 it loads the upper word: bits [9:0] are the upper block bound, bit [10] the override, and bit [11] the enable. Decoding uses the new values from the cycle after the write.
- R3: In memory space (io_space=0) the block index is addr[19:10]. The output selects when lower <= index < upper.
- R4: In I/O space (io_space=1) the block index is addr[15:6], and addr[19:16] have no effect.
- R5: With the override set, the upper comparison is treated as true. The window then runs to the last address of the space.
- R6: With the enable clear, cs_n never goes low, whatever the address.
- R7: With upper <= lower, the window is empty and cs_n stays high.
- R8: The override is stored as 1 only if the same upper-word write carries an upper bound greater than the current lower bound. A lower-word write whose bound is at or above the stored upper bound clears the override.
- R9: cs_n is registered. It goes low one edge after the block samples addr_valid=1, cycle_end=0 and an address inside the window. It is high in every cycle that follows a sample with addr_valid=0 or cycle_end=1.
- R10: When cs_n falls, the wait count is loaded. int_rdy stays low for that many cycles of cs_n low. Its earliest assertion is in cs_n-low cycle number WS+1.
- R11: Once the count has run out: with the ready-ignore flag set, int_rdy is 1 regardless of ext_rdy. With the flag clear, int_rdy follows ext_rdy in the same cycle.
- R12: int_rdy is never 1 while cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0 selects the lower word, 1 the upper word |
| cfg_wr_data | input | 16 | Configuration write data |
| addr | input | 20 | Bus address |
| io_space | input | 1 | 1 selects I/O space, 0 memory space |
| addr_valid | input | 1 | Address-valid strobe |
| cycle_end | input | 1 | One-cycle end-of-bus-cycle pulse |
| ext_rdy | input | 1 | External ready, active high |
| cs_n | output | 1 | Registered active-low chip-select |
| int_rdy | output | 1 | Internal ready for the selected cycle |

## Verification
cs_n is due one clock edge after the sampled address, strobe and cycle-end. A configuration write changes decoding from the edge after the one that stored it. int_rdy comes from the registered wait counter and the live ext_rdy, so it can change within a cycle when ext_rdy moves.

The bench drives inputs on the falling edge. It advances its reference model on the rising edge, then compares both outputs a quarter period later. This means every cycle is checked exactly where each result is due. The window boundaries, the override lock and wait counts with and without the ready-ignore flag all fall under this cycle-exact comparison.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_BLK_W = 10;
  localparam int CS_WS_W  = 4;

  typedef struct packed {
    logic [CS_BLK_W-1:0] blk;
    logic [CS_WS_W-1:0]  ws;
    logic                ign_rdy;
  } lo_cfg_t;

  typedef struct packed {
    logic [CS_BLK_W-1:0] blk;
    logic                top_ovr;
    logic                enable;
  } hi_cfg_t;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output lo_cfg_t           lo_q,
  output hi_cfg_t           hi_q
);
  localparam int WS_LSB  = CS_BLK_W;
  localparam int IGN_BIT = CS_BLK_W + CS_WS_W;
  localparam int OVR_BIT = CS_BLK_W;
  localparam int EN_BIT  = CS_BLK_W + 1;

  logic [CS_BLK_W-1:0] d_blk;
  assign d_blk = wr_data[CS_BLK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q.blk     <= '0;
      lo_q.ws      <= '1;
      lo_q.ign_rdy <= 1'b0;
      hi_q.blk     <= '0;
      hi_q.top_ovr <= 1'b0;
      hi_q.enable  <= 1'b0;
    end else if (wr_en) begin
      if (!wr_sel) begin
        lo_q.blk     <= d_blk;
        lo_q.ws      <= wr_data[WS_LSB +: CS_WS_W];
        lo_q.ign_rdy <= wr_data[IGN_BIT];
        if (hi_q.blk <= d_blk) hi_q.top_ovr <= 1'b0;
      end else begin
        hi_q.blk     <= d_blk;
        hi_q.top_ovr <= wr_data[OVR_BIT] && (d_blk > lo_q.blk);
        hi_q.enable  <= wr_data[EN_BIT];
      end
    end
  end
endmodule

// File: rtl/cs_range_cmp.sv
module cs_range_cmp
  import cs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                io_space,
  input  logic [CS_BLK_W-1:0] lo_blk,
  input  logic [CS_BLK_W-1:0] hi_blk,
  input  logic                top_ovr,
  input  logic                enable,
  output logic                hit
);
  localparam int MEM_LSB = ADDR_W - CS_BLK_W;
  localparam int IO_LSB  = IO_W - CS_BLK_W;

  logic [CS_BLK_W-1:0] idx;
  logic above_lo, below_hi;

  always_comb begin
    idx      = io_space ? addr[IO_LSB +: CS_BLK_W] : addr[MEM_LSB +: CS_BLK_W];
    above_lo = (idx >= lo_blk);
    below_hi = top_ovr || (idx < hi_blk);
    hit      = enable && above_lo && below_hi;
  end
endmodule

// File: rtl/cs_wait_ctr.sv
module cs_wait_ctr
  import cs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_next,
  input  logic               sel_q,
  input  logic [CS_WS_W-1:0] ws,
  input  logic               ign_rdy,
  input  logic               ext_rdy,
  output logic               rdy
);
  logic [CS_WS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (sel_next && !sel_q)       cnt_q <= ws;
    else if (sel_q && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign rdy = sel_q && (cnt_q == '0) && (ign_rdy || ext_rdy);
endmodule

// File: rtl/cs_range_decoder.sv
module cs_range_decoder
  import cs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_sel,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_space,
  input  logic              addr_valid,
  input  logic              cycle_end,
  input  logic              ext_rdy,
  output logic              cs_n,
  output logic              int_rdy
);
  lo_cfg_t lo_q;
  hi_cfg_t hi_q;
  logic    hit, sel_next, sel_q;

  cs_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .lo_q(lo_q), .hi_q(hi_q)
  );

  cs_range_cmp #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_cmp (
    .addr(addr), .io_space(io_space), .lo_blk(lo_q.blk), .hi_blk(hi_q.blk),
    .top_ovr(hi_q.top_ovr), .enable(hi_q.enable), .hit(hit)
  );

  assign sel_next = addr_valid && !cycle_end && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_next;
  end

  assign cs_n = !sel_q;

  cs_wait_ctr u_wait (
    .clk(clk), .rst_n(rst_n), .sel_next(sel_next), .sel_q(sel_q),
    .ws(lo_q.ws), .ign_rdy(lo_q.ign_rdy), .ext_rdy(ext_rdy), .rdy(int_rdy)
  );
endmodule

// File: rtl/cs_range_decoder_chk.sv
module cs_range_decoder_chk
  import cs_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    addr_valid,
  input logic    cycle_end,
  input logic    cs_n,
  input logic    int_rdy,
  input lo_cfg_t lo_q,
  input hi_cfg_t hi_q,
  input logic [CS_WS_W-1:0] cnt_q
);
  // R9
  cs_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> $past(addr_valid) && !$past(cycle_end));
  // R12
  rdy_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rdy |-> !cs_n);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hi_q.enable) |-> cs_n);
  // R8
  ovr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q.top_ovr |-> hi_q.blk > lo_q.blk);
  // R10
  wait_holds_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !int_rdy);
endmodule

bind cs_range_decoder cs_range_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .cycle_end(cycle_end),
  .cs_n(cs_n), .int_rdy(int_rdy), .lo_q(lo_q), .hi_q(hi_q), .cnt_q(u_wait.cnt_q)
);

// File: tb/cs_range_decoder_tb.sv
module cs_range_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [19:0] addr = '0;
  logic        io_space = 1'b0, addr_valid = 1'b0, cycle_end = 1'b0, ext_rdy = 1'b0;
  logic        cs_n, int_rdy;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference model state
  int m_lo = 0, m_ws = 15, m_hi = 0, m_cnt = 0;
  bit m_ign = 0, m_ovr = 0, m_en = 0, m_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_range_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .addr(addr), .io_space(io_space),
    .addr_valid(addr_valid), .cycle_end(cycle_end), .ext_rdy(ext_rdy),
    .cs_n(cs_n), .int_rdy(int_rdy)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_ws = 15; m_ign = 0; m_hi = 0; m_ovr = 0; m_en = 0;
      m_sel = 0; m_cnt = 0;
    end else begin
      int idx;
      bit nsel;
      idx  = io_space ? int'((addr >> 6) & 20'h3FF) : int'((addr >> 10) & 20'h3FF);
      nsel = addr_valid && !cycle_end && m_en && idx >= m_lo && (m_ovr || idx < m_hi);
      if (nsel && !m_sel) m_cnt = m_ws;
      else if (m_sel && m_cnt > 0) m_cnt = m_cnt - 1;
      m_sel = nsel;
      if (cfg_wr_en) begin
        int d;
        d = int'(cfg_wr_data[9:0]);
        if (!cfg_wr_sel) begin
          m_lo = d; m_ws = int'(cfg_wr_data[13:10]); m_ign = cfg_wr_data[14];
          if (m_hi <= d) m_ovr = 0;
        end else begin
          m_hi = d; m_ovr = cfg_wr_data[10] && (d > m_lo); m_en = cfg_wr_data[11];
        end
      end
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      bit exp_cs_n, exp_rdy;
      exp_cs_n = !m_sel;
      exp_rdy  = m_sel && m_cnt == 0 && (m_ign || ext_rdy);
      n_chk++;
      if (cs_n !== exp_cs_n) begin
        n_bad++;
        $display("FAIL %s cs_n actual=%b expected=%b at %0t", tag, cs_n, exp_cs_n, $time);
      end
      n_chk++;
      if (int_rdy !== exp_rdy) begin
        n_bad++;
        $display("FAIL %s int_rdy actual=%b expected=%b at %0t", tag, int_rdy, exp_rdy, $time);
      end
    end
  end

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic bus(input logic [19:0] a, input bit io, input int len);
    @(negedge clk);
    addr = a; io_space = io; addr_valid = 1'b1;
    for (int i = 0; i < len; i++) @(negedge clk);
    cycle_end = 1'b1;
    @(negedge clk);
    cycle_end = 1'b0; addr_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] lo_w(int blk, int ws, bit ign);
    return {1'b0, ign, 4'(ws), 10'(blk)};
  endfunction
  function automatic logic [15:0] hi_w(int blk, bit ovr, bit en);
    return {4'b0, en, ovr, 10'(blk)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state and defaults (no selection before programming)
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; bus(20'h40000, 0, 3);
    // R2 + R3: memory window [0x100,0x200) blocks, no wait, ignore ready
    tag = "R2"; wr(0, lo_w('h100, 0, 1)); wr(1, hi_w('h200, 0, 1));
    tag = "R3";
    bus(20'h40000, 0, 2); bus(20'h7FFFF, 0, 2);
    bus(20'h80000, 0, 2); bus(20'h3FFFF, 0, 2);
    // R4: I/O index addr[15:6], upper bits ignored
    tag = "R4";
    bus(20'h04000, 1, 2); bus(20'hF7FFF, 1, 2);
    bus(20'h08000, 1, 2); bus(20'hF3FFF, 1, 2);
    // R5: override reaches top of space
    tag = "R5"; wr(1, hi_w('h3FF, 0, 1)); bus(20'hFFFFF, 0, 2);
    wr(1, hi_w('h3FF, 1, 1)); bus(20'hFFFFF, 0, 2); bus(20'hFFFF, 1, 2);
    // R6: enable clear
    tag = "R6"; wr(1, hi_w('h3FF, 1, 0)); bus(20'h50000, 0, 2); bus(20'hFFFFF, 0, 2);
    // R7 + R8: empty window, override refused
    tag = "R7"; wr(1, hi_w('h100, 1, 1)); bus(20'h40000, 0, 2); bus(20'hFFFFF, 0, 2);
    tag = "R8"; wr(1, hi_w('h3FF, 1, 1)); bus(20'hFFFFF, 0, 2);
    wr(0, lo_w('h3FF, 0, 1)); wr(0, lo_w('h100, 0, 1)); bus(20'hFFFFF, 0, 2);
    bus(20'hFFBFF, 0, 2);
    // R9: cycle_end and strobe removal drop cs_n; write takes effect next cycle
    tag = "R9"; wr(1, hi_w('h200, 0, 1));
    @(negedge clk); addr = 20'h50000; io_space = 0; addr_valid = 1'b1;
    cfg_wr_en = 1'b1; cfg_wr_sel = 1'b1; cfg_wr_data = hi_w('h200, 0, 0);
    @(negedge clk); cfg_wr_en = 1'b0;
    @(negedge clk); addr_valid = 1'b0;
    @(negedge clk); wr(1, hi_w('h200, 0, 1));
    bus(20'h50000, 0, 1);
    // R10: wait count with ready ignored
    tag = "R10"; wr(0, lo_w('h100, 3, 1)); bus(20'h50000, 0, 6);
    wr(0, lo_w('h100, 15, 1)); bus(20'h50000, 0, 18);
    // R11: ready required, toggled mid cycle
    tag = "R11"; wr(0, lo_w('h100, 2, 0));
    @(negedge clk); ext_rdy = 1'b0; addr = 20'h50000; addr_valid = 1'b1;
    repeat (5) @(negedge clk);
    ext_rdy = 1'b1; @(negedge clk); ext_rdy = 1'b0; @(negedge clk);
    ext_rdy = 1'b1; cycle_end = 1'b1; @(negedge clk);
    cycle_end = 1'b0; addr_valid = 1'b0; @(negedge clk);
    // R12: ext_rdy high while unselected
    tag = "R12"; ext_rdy = 1'b1; bus(20'h10000, 0, 3); bus(20'h50000, 1, 2);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule